// File: doc/BRIEF.md
# Boot Vector Fetch Sequencer

This block starts a small processor core after reset. Reset leaves it idle. Once reset is released it reads two words through a word-read memory port that uses a valid/ready handshake. The word at address 0 becomes the initial stack pointer. The word at address 4 becomes the initial program counter. Bit 0 of the program-counter word is not treated as an address bit. It is split off into a separate execution-state flag, and the program counter handed to the core has that bit forced to zero.

An integrator can set the bypass input so that an explicit entry address is used instead of the table. In that case no memory reads take place. The entry address, with bit 0 split off in the same way, becomes the program counter, and the stack pointer keeps its reset value of zero. When the last required step is complete, a single-cycle done pulse releases the core. All outputs then stay unchanged until the next reset. Asserting reset part-way through the sequence abandons it, and the sequence starts again from the first fetch.

Top module: `boot_vector_fetch`

## Requirements
- R1: While reset (active-low rstN) is asserted, rdValid and bootDone are 0 and initSp, initPc and execState are 0.
- R2: When bypassEn is 0 in the first cycle after reset release, the first read presents rdAddr = 0. rdValid and rdAddr hold steady until rdReady completes the handshake.
- R3: initSp takes the value of rdData in the cycle the address-0 read completes.
- R4: The address-4 read is issued only after the address-0 read has completed, and no other reads are made.
- R5: initPc equals the fetched address-4 word with bit 0 cleared.
- R6: execState equals bit 0 of the fetched address-4 word.
- R7: bootDone is high for exactly one cycle, in the cycle right after the last handshake completes. It does not rise again, and no further reads are made, until the next reset.
- R8: After bootDone, initSp, initPc and execState stay constant, even if rdData, bypassEn or bypassEntry change.
- R9: When bypassEn is 1 in the first cycle after reset release, no read is issued. initPc is bypassEntry with bit 0 cleared, execState is bypassEntry bit 0, and initSp stays 0.
- R10: A reset asserted during either fetch abandons the sequence without a bootDone pulse. The next run starts again with the address-0 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bypassEn | input | 1 | Use bypassEntry instead of the vector table |
| bypassEntry | input | 32 | Explicit entry address for the bypass path |
| rdValid | output | 1 | Read request valid |
| rdAddr | output | 32 | Read word address |
| rdReady | input | 1 | Memory accepts the request; rdData is valid in the same cycle |
| rdData | input | 32 | Read data |
| initSp | output | 32 | Initial stack pointer |
| initPc | output | 32 | Initial program counter, bit 0 cleared |
| execState | output | 1 | Execution-state flag taken from entry bit 0 |
| bootDone | output | 1 | One-cycle release pulse |

## Verification
The table path runs with a zero-wait memory and with several wait states. This shows that the handshake is honoured and not assumed to complete at once. The program-counter word is given an odd value in one run and an even value in another, so a flag wired to the wrong bit, or a bit 0 left uncleared, shows up. The bypass path runs with odd and even entry addresses and checks that no reads occur. Reset is applied both during the stack-pointer fetch and during the program-counter fetch, which separates a true restart from a design that resumes where it stopped.

// File: rtl/bootvec_pkg.sv
package bootvec_pkg;

  typedef enum logic [2:0] {
    SEQ_START,
    SEQ_SP,
    SEQ_PC,
    SEQ_DONE,
    SEQ_HOLD
  } seq_state_e;

  // control-to-datapath load strobes
  typedef struct packed {
    logic ldSp;
    logic ldPcMem;
    logic ldPcByp;
  } load_strobe_t;

endpackage

// File: rtl/boot_vector_ctrl.sv
module boot_vector_ctrl
  import bootvec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SP_ADDR = 0,
  parameter int PC_ADDR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bypassEn,
  input  logic              rdReady,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              bootDone,
  output load_strobe_t      strobe
);

  seq_state_e seqState, seqNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqState <= SEQ_START;
    else       seqState <= seqNext;
  end

  always_comb begin
    seqNext = seqState;
    unique case (seqState)
      SEQ_START: seqNext = bypassEn ? SEQ_DONE : SEQ_SP;
      SEQ_SP:    if (rdReady) seqNext = SEQ_PC;
      SEQ_PC:    if (rdReady) seqNext = SEQ_DONE;
      SEQ_DONE:  seqNext = SEQ_HOLD;
      SEQ_HOLD:  seqNext = SEQ_HOLD;
      default:   seqNext = SEQ_START;
    endcase
  end

  assign rdValid  = (seqState == SEQ_SP) || (seqState == SEQ_PC);
  assign rdAddr   = (seqState == SEQ_SP) ? ADDR_W'(SP_ADDR) : ADDR_W'(PC_ADDR);
  assign bootDone = (seqState == SEQ_DONE);

  always_comb begin
    strobe         = '0;
    strobe.ldSp    = (seqState == SEQ_SP) && rdReady;
    strobe.ldPcMem = (seqState == SEQ_PC) && rdReady;
    strobe.ldPcByp = (seqState == SEQ_START) && bypassEn;
  end

  // tracks completion for the assertions below
  logic doneSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         doneSeen <= 1'b0;
    else if (bootDone) doneSeen <= 1'b1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid && $stable(rdAddr)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> !bootDone); // R7
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |-> !rdValid && !bootDone); // R7
  AST_SP_BEFORE_PC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldSp |=> rdValid && rdAddr == ADDR_W'(PC_ADDR)); // R4

endmodule

// File: rtl/boot_vector_dp.sv
module boot_vector_dp
  import bootvec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  load_strobe_t      strobe,
  input  logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] bypassEntry,
  output logic [DATA_W-1:0] initSp,
  output logic [DATA_W-1:0] initPc,
  output logic              execState
);

  logic [DATA_W-1:0] pcSrc;
  assign pcSrc = strobe.ldPcByp ? bypassEntry : rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initSp    <= '0;
      initPc    <= '0;
      execState <= 1'b0;
    end else begin
      if (strobe.ldSp) initSp <= rdData;
      if (strobe.ldPcMem || strobe.ldPcByp) begin
        initPc    <= {pcSrc[DATA_W-1:1], 1'b0};
        execState <= pcSrc[0];
      end
    end
  end

  AST_SP_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldSp |=> initSp == $past(rdData)); // R3
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    initPc[0] == 1'b0); // R5
  AST_FLAG_FROM_MEM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldPcMem |=> execState == $past(rdData[0])); // R6
  AST_FLAG_FROM_BYP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldPcByp |=> execState == $past(bypassEntry[0])); // R9

endmodule

// File: rtl/boot_vector_fetch.sv
module boot_vector_fetch
  import bootvec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SP_ADDR = 0,
  parameter int PC_ADDR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bypassEn,
  input  logic [DATA_W-1:0] bypassEntry,
  output logic              rdValid,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdReady,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] initSp,
  output logic [DATA_W-1:0] initPc,
  output logic              execState,
  output logic              bootDone
);

  load_strobe_t strobe;

  boot_vector_ctrl #(
    .ADDR_W (ADDR_W),
    .SP_ADDR(SP_ADDR),
    .PC_ADDR(PC_ADDR)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .bypassEn(bypassEn),
    .rdReady (rdReady),
    .rdValid (rdValid),
    .rdAddr  (rdAddr),
    .bootDone(bootDone),
    .strobe  (strobe)
  );

  boot_vector_dp #(
    .DATA_W(DATA_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rdData     (rdData),
    .bypassEntry(bypassEntry),
    .initSp     (initSp),
    .initPc     (initPc),
    .execState  (execState)
  );

  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |-> $past(strobe.ldPcMem || strobe.ldPcByp)); // R7

endmodule

// File: tb/sim_boot_vector_fetch.sv
module sim_boot_vector_fetch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bypassEn = 1'b0;
  logic [31:0] bypassEntry = '0;
  logic        rdValid;
  logic [31:0] rdAddr;
  logic        rdReady = 1'b0;
  logic [31:0] rdData;
  logic [31:0] initSp, initPc;
  logic        execState, bootDone;

  always #10 clk = ~clk;  // 50 MHz

  boot_vector_fetch u0 (
    .clk(clk), .rstN(rstN), .bypassEn(bypassEn), .bypassEntry(bypassEntry),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdReady(rdReady), .rdData(rdData),
    .initSp(initSp), .initPc(initPc), .execState(execState), .bootDone(bootDone)
  );

  typedef struct {
    logic [31:0] sp;
    logic [31:0] pc;
    logic        flag;
    bit          byp;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] logAddr[$];
  logic [31:0] memSp, memPc;
  int          lat = 0;
  int          waitCnt = 0;
  int          cyc = 0;
  int          hsCyc = -10;
  int          doneCnt = 0;
  bit          prevDone = 0;
  int          nChecks = 0;
  int          nFail = 0;

  assign rdData = (rdAddr == 32'd0) ? memSp :
                  (rdAddr == 32'd4) ? memPc : 32'hDEAD_BEEF;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder and monitor, away from the active edge
  always @(negedge clk) begin
    bit rdy;
    exp_t e;
    cyc++;
    rdy = rstN && rdValid && (waitCnt >= lat);
    if (rdy) waitCnt = 0;
    else if (rdValid) waitCnt++;
    else waitCnt = 0;
    rdReady = rdy;
    if (rdy) begin
      logAddr.push_back(rdAddr);
      hsCyc = cyc;
    end
    if (rstN && bootDone) begin
      doneCnt++;
      chk(!prevDone, "R7 done width", 32'(prevDone), 32'd0);
      if (expQ.size() == 0) begin
        chk(0, "R10 unexpected done", 32'd1, 32'd0);
      end else begin
        e = expQ.pop_front();
        if (!e.byp) chk(cyc == hsCyc + 1, "R7 done timing", 32'(cyc - hsCyc), 32'd1);
        chk(initSp == e.sp, e.byp ? "R9 sp" : "R3 sp", initSp, e.sp);
        chk(initPc == e.pc, e.byp ? "R9 pc" : "R5 pc", initPc, e.pc);
        chk(execState == e.flag, e.byp ? "R9 flag" : "R6 flag", 32'(execState), 32'(e.flag));
      end
    end
    prevDone = rstN && bootDone;
  end

  task automatic runBoot(bit byp, logic [31:0] ent, logic [31:0] sp,
                         logic [31:0] pc, int l);
    exp_t e;
    int d0;
    int nLog;
    @(posedge clk); #5;
    rstN = 1'b0;
    bypassEn = byp; bypassEntry = ent; memSp = sp; memPc = pc; lat = l;
    logAddr.delete();
    e.sp = byp ? 32'd0 : sp;
    e.pc = (byp ? ent : pc) & ~32'd1;
    e.flag = byp ? ent[0] : pc[0];
    e.byp = byp;
    expQ.push_back(e);
    @(posedge clk); #5;
    chk(!rdValid && !bootDone, "R1 idle in reset", {rdValid, bootDone}, 32'd0);
    chk(initSp == 0 && initPc == 0 && !execState, "R1 outputs zero", initPc, 32'd0);
    d0 = doneCnt;
    rstN = 1'b1;
    for (int i = 0; i < 60 && doneCnt == d0; i++) @(posedge clk);
    chk(doneCnt == d0 + 1, "R7 one done", doneCnt - d0, 32'd1);
    if (byp) begin
      chk(logAddr.size() == 0, "R9 no reads", logAddr.size(), 32'd0);
    end else begin
      chk(logAddr.size() == 2, "R4 read count", logAddr.size(), 32'd2);
      if (logAddr.size() == 2) begin
        chk(logAddr[0] == 32'd0, "R2 first addr", logAddr[0], 32'd0);
        chk(logAddr[1] == 32'd4, "R4 second addr", logAddr[1], 32'd4);
      end
    end
    nLog = logAddr.size();
    repeat (3) @(posedge clk); #5;
    memSp = ~sp; memPc = ~pc; bypassEn = ~byp; bypassEntry = ~ent;
    repeat (6) @(posedge clk); #5;
    chk(initSp == e.sp, "R8 sp stable", initSp, e.sp);
    chk(initPc == e.pc, "R8 pc stable", initPc, e.pc);
    chk(execState == e.flag, "R8 flag stable", 32'(execState), 32'(e.flag));
    chk(doneCnt == d0 + 1 && logAddr.size() == nLog, "R7 quiet after done",
        doneCnt - d0, 32'd1);
  endtask

  // start a run, then reset it while the given fetch is pending
  task automatic abortAt(logic [31:0] pendAddr, int waitCycles);
    int d0;
    @(posedge clk); #5;
    rstN = 1'b0; bypassEn = 1'b0; memSp = 32'h1111_0000; memPc = 32'h2222_0001;
    lat = 4; logAddr.delete();
    @(posedge clk); #5;
    d0 = doneCnt;
    rstN = 1'b1;
    repeat (waitCycles) @(posedge clk); #5;
    chk(rdValid && rdAddr == pendAddr, "R10 pending fetch", rdAddr, pendAddr);
    rstN = 1'b0;
    #1;
    chk(!rdValid && !bootDone, "R1 async abort", 32'(rdValid), 32'd0);
    chk(doneCnt == d0, "R10 no done on abort", doneCnt - d0, 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    runBoot(0, 32'h0, 32'h2000_8000, 32'h0000_0101, 0);  // R2 R3 R5 R6 odd pc
    runBoot(0, 32'h0, 32'h2000_4000, 32'h0000_0200, 3);  // R2 wait states, even pc
    runBoot(1, 32'h0800_0045, 32'h5555_5555, 32'h7777_7777, 0); // R9 odd entry
    runBoot(1, 32'h0800_0100, 32'h5555_5555, 32'h7777_7777, 2); // R9 even entry
    abortAt(32'd0, 2);   // R10 during SP fetch
    runBoot(0, 32'h0, 32'hAAAA_0000, 32'hBBBB_0003, 1);
    abortAt(32'd4, 8);   // R10 during PC fetch
    runBoot(0, 32'h0, 32'hCCCC_0010, 32'hDDDD_0020, 2);
    chk(expQ.size() == 0, "R7 all runs done", expQ.size(), 32'd0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule